// File: doc/BRIEF.md
# Pipeline Hazard Detection and Forwarding Unit

This block is the hazard controller of a five-stage in-order pipeline whose stages are fetch, decode, execute, memory and writeback, with branches resolved in decode. It takes the register numbers carried by each stage and the write and load flags of the later stages. From these it produces bypass selects for the two execute ALU operands and the two decode comparator operands. It also produces one stall condition that holds the fetch and decode registers and clears the execute register.

Every output is a pure combinational function of the current stage fields, and the block holds no state. The surrounding datapath applies the selects to its operand multiplexers and the stall and flush to its pipeline register enables and clears.

Top module: `hazard_unit`

## Requirements
- R1: `fwdAE` is 2'b10 (take the memory-stage result) when `rsE` is nonzero, `regWrM` is 1 and `rsE` equals `dstM`.
- R2: When R1 does not apply, `fwdAE` is 2'b01 (take the writeback result) if `rsE` is nonzero, `regWrW` is 1 and `rsE` equals `dstW`. Otherwise `fwdAE` is 2'b00 (register file value).
- R3: When the memory stage and the writeback stage both match an execute source, the select is 2'b10.
- R4: Register 0 is never forwarded. A zero source number gives a select of 0 on all four forwarding outputs, whatever the destinations and flags are.
- R5: `fwdBE` follows the rules of R1 to R3 with `rtE` as the source.
- R6: `fwdAD` is 1 when `rsD` is nonzero, `regWrM` is 1 and `rsD` equals `dstM`. `fwdBD` follows the same rule with `rtD`. Otherwise each is 0.
- R7: A load-use stall is raised when `memToRegE` is 1 and `rtE` equals either `rsD` or `rtD`.
- R8: With `branchD` at 1, a stall is raised when `regWrE` is 1 and `dstE` equals `rsD` or `rtD`.
- R9: With `branchD` at 1, a stall is raised when `memToRegM` is 1 and `dstM` equals `rsD` or `rtD`.
- R10: `stallF`, `stallD` and `flushE` are equal to one another and to the OR of the R7, R8 and R9 conditions. All three are 0 when none of those conditions holds, and also when every input is 0.
- R11: The outputs follow the inputs in the same cycle, with no register on any path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rsD | input | REG_BITS | First source register in decode |
| rtD | input | REG_BITS | Second source register in decode |
| rsE | input | REG_BITS | First source register in execute |
| rtE | input | REG_BITS | Second source register in execute |
| dstE | input | REG_BITS | Destination register in execute |
| dstM | input | REG_BITS | Destination register in memory |
| dstW | input | REG_BITS | Destination register in writeback |
| regWrE | input | 1 | Execute instruction writes a register |
| regWrM | input | 1 | Memory instruction writes a register |
| regWrW | input | 1 | Writeback instruction writes a register |
| memToRegE | input | 1 | Execute instruction is a load |
| memToRegM | input | 1 | Memory instruction is a load |
| branchD | input | 1 | Decode instruction is a branch |
| fwdAE | output | 2 | Execute operand A select |
| fwdBE | output | 2 | Execute operand B select |
| fwdAD | output | 1 | Decode comparator A select |
| fwdBD | output | 1 | Decode comparator B select |
| stallF | output | 1 | Hold the fetch register |
| stallD | output | 1 | Hold the decode register |
| flushE | output | 1 | Clear the execute register |

## Verification
Two pairs of functions can act in the same cycle. The memory and writeback bypass paths can both claim one execute operand, and a load-use stall can coincide with a branch stall. The bench provokes both by drawing register numbers at random from a range of four, so that matches between stages are frequent, and it adds directed vectors in which both bypass stages target one source. Each output is compared with a reference model that applies the memory-first priority and ORs the stall causes together.

// File: rtl/hazard_pkg.sv
package hazard_pkg;
  // Execute operand bypass select encoding
  typedef enum logic [1:0] {
    SEL_RF  = 2'b00,
    SEL_WB  = 2'b01,
    SEL_MEM = 2'b10
  } fwd_sel_e;

  // Stall causes reported by the control half
  typedef struct packed {
    logic loadUse;
    logic branchWait;
  } hz_strobe_t;
endpackage

// File: rtl/hazard_fwd.sv
module hazard_fwd
  import hazard_pkg::*;
#(
  parameter int REG_BITS = 5,
  parameter int NUM_SRC  = 2
) (
  input  logic [NUM_SRC-1:0][REG_BITS-1:0] srcE,
  input  logic [NUM_SRC-1:0][REG_BITS-1:0] srcD,
  input  logic [REG_BITS-1:0]              dstM,
  input  logic [REG_BITS-1:0]              dstW,
  input  logic                             regWrM,
  input  logic                             regWrW,
  output logic [NUM_SRC-1:0][1:0]          selE,
  output logic [NUM_SRC-1:0]               selD
);
  localparam logic [REG_BITS-1:0] ZERO_REG = '0;

  for (genvar i = 0; i < NUM_SRC; i++) begin : gSrc
    fwd_sel_e sel;
    logic     memHitE, wbHitE, memHitD;

    assign memHitE = (srcE[i] != ZERO_REG) && regWrM && (srcE[i] == dstM);
    assign wbHitE  = (srcE[i] != ZERO_REG) && regWrW && (srcE[i] == dstW);
    assign memHitD = (srcD[i] != ZERO_REG) && regWrM && (srcD[i] == dstM);

    // Memory stage holds the younger result, so it wins
    always_comb begin
      if (memHitE)     sel = SEL_MEM;
      else if (wbHitE) sel = SEL_WB;
      else             sel = SEL_RF;
    end

    assign selE[i] = sel;
    assign selD[i] = memHitD;
  end
endmodule

// File: rtl/hazard_ctrl.sv
module hazard_ctrl
  import hazard_pkg::*;
#(
  parameter int REG_BITS = 5
) (
  input  logic [REG_BITS-1:0] rsD,
  input  logic [REG_BITS-1:0] rtD,
  input  logic [REG_BITS-1:0] rtE,
  input  logic [REG_BITS-1:0] dstE,
  input  logic [REG_BITS-1:0] dstM,
  input  logic                regWrE,
  input  logic                memToRegE,
  input  logic                memToRegM,
  input  logic                branchD,
  output hz_strobe_t          strobes
);
  logic loadHit, aluHitE, loadHitM;

  // A load in execute lands in rtE; decode must wait a cycle
  assign loadHit  = memToRegE && ((rsD == rtE) || (rtD == rtE));
  // A branch compares in decode, so results not yet bypassable block it
  assign aluHitE  = regWrE && ((dstE == rsD) || (dstE == rtD));
  assign loadHitM = memToRegM && ((dstM == rsD) || (dstM == rtD));

  always_comb begin
    strobes.loadUse    = loadHit;
    strobes.branchWait = branchD && (aluHitE || loadHitM);
  end
endmodule

// File: rtl/hazard_unit.sv
module hazard_unit
  import hazard_pkg::*;
#(
  parameter int REG_BITS = 5
) (
  input  logic [REG_BITS-1:0] rsD,
  input  logic [REG_BITS-1:0] rtD,
  input  logic [REG_BITS-1:0] rsE,
  input  logic [REG_BITS-1:0] rtE,
  input  logic [REG_BITS-1:0] dstE,
  input  logic [REG_BITS-1:0] dstM,
  input  logic [REG_BITS-1:0] dstW,
  input  logic                regWrE,
  input  logic                regWrM,
  input  logic                regWrW,
  input  logic                memToRegE,
  input  logic                memToRegM,
  input  logic                branchD,
  output logic [1:0]          fwdAE,
  output logic [1:0]          fwdBE,
  output logic                fwdAD,
  output logic                fwdBD,
  output logic                stallF,
  output logic                stallD,
  output logic                flushE
);
  localparam int NUM_SRC = 2;

  logic [NUM_SRC-1:0][REG_BITS-1:0] srcE, srcD;
  logic [NUM_SRC-1:0][1:0]          selE;
  logic [NUM_SRC-1:0]               selD;
  hz_strobe_t                       strobes;
  logic                             holdFront;

  assign srcE = {rtE, rsE};
  assign srcD = {rtD, rsD};

  hazard_fwd #(.REG_BITS(REG_BITS), .NUM_SRC(NUM_SRC)) uFwd (
    .srcE(srcE), .srcD(srcD), .dstM(dstM), .dstW(dstW),
    .regWrM(regWrM), .regWrW(regWrW), .selE(selE), .selD(selD)
  );

  hazard_ctrl #(.REG_BITS(REG_BITS)) uCtrl (
    .rsD(rsD), .rtD(rtD), .rtE(rtE), .dstE(dstE), .dstM(dstM),
    .regWrE(regWrE), .memToRegE(memToRegE), .memToRegM(memToRegM),
    .branchD(branchD), .strobes(strobes)
  );

  assign holdFront = strobes.loadUse | strobes.branchWait;

  assign fwdAE  = selE[0];
  assign fwdBE  = selE[1];
  assign fwdAD  = selD[0];
  assign fwdBD  = selD[1];
  assign stallF = holdFront;
  assign stallD = holdFront;
  assign flushE = holdFront;
endmodule

// File: rtl/hazard_unit_checker.sv
module hazard_unit_checker #(
  parameter int REG_BITS = 5
) (
  input logic [REG_BITS-1:0] rsD,
  input logic [REG_BITS-1:0] rtD,
  input logic [REG_BITS-1:0] rsE,
  input logic [REG_BITS-1:0] rtE,
  input logic [REG_BITS-1:0] dstM,
  input logic [REG_BITS-1:0] dstW,
  input logic                regWrM,
  input logic                regWrW,
  input logic                memToRegE,
  input logic                memToRegM,
  input logic                branchD,
  input logic [1:0]          fwdAE,
  input logic [1:0]          fwdBE,
  input logic                fwdAD,
  input logic                stallF,
  input logic                stallD,
  input logic                flushE
);
  always_comb begin
    assert_mem_sel_R1: assert (fwdAE != 2'b10 ||
      (regWrM && rsE != '0 && rsE == dstM))
      else $error("memory bypass without a memory match");
    assert_wb_sel_R2: assert (fwdAE != 2'b01 ||
      (regWrW && rsE != '0 && rsE == dstW && !(regWrM && rsE == dstM)))
      else $error("writeback bypass chosen wrongly");
    assert_mem_first_R3: assert (!(regWrM && rsE != '0 && rsE == dstM) || fwdAE == 2'b10)
      else $error("memory match lost priority");
    assert_zero_reg_R4: assert ((rsE != '0 || fwdAE == 2'b00) && (rtE != '0 || fwdBE == 2'b00))
      else $error("register 0 forwarded");
    assert_decode_sel_R6: assert (!fwdAD || (regWrM && rsD != '0 && rsD == dstM))
      else $error("decode bypass without a match");
    assert_load_use_R7: assert (!(memToRegE && (rsD == rtE || rtD == rtE)) || stallF)
      else $error("load-use hazard not stalled");
    assert_branch_load_R9: assert (!(branchD && memToRegM && (dstM == rsD || dstM == rtD)) || stallF)
      else $error("branch after load not stalled");
    assert_hold_align_R10: assert (stallF == stallD && stallD == flushE)
      else $error("stall and flush disagree");
  end
endmodule

bind hazard_unit hazard_unit_checker #(.REG_BITS(REG_BITS)) uChk (
  .rsD(rsD), .rtD(rtD), .rsE(rsE), .rtE(rtE), .dstM(dstM), .dstW(dstW),
  .regWrM(regWrM), .regWrW(regWrW), .memToRegE(memToRegE),
  .memToRegM(memToRegM), .branchD(branchD), .fwdAE(fwdAE), .fwdBE(fwdBE),
  .fwdAD(fwdAD), .stallF(stallF), .stallD(stallD), .flushE(flushE)
);

// File: tb/hazard_unit_test.sv
`timescale 1ns/1ps
module hazard_unit_test;
  localparam int RB = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [RB-1:0] rsD, rtD, rsE, rtE, dstE, dstM, dstW;
  logic regWrE, regWrM, regWrW, memToRegE, memToRegM, branchD;
  logic [1:0] fwdAE, fwdBE;
  logic fwdAD, fwdBD, stallF, stallD, flushE;

  int testCount = 0;
  int failCount = 0;
  bit done = 0;

  hazard_unit #(.REG_BITS(RB)) uut (
    .rsD(rsD), .rtD(rtD), .rsE(rsE), .rtE(rtE), .dstE(dstE), .dstM(dstM),
    .dstW(dstW), .regWrE(regWrE), .regWrM(regWrM), .regWrW(regWrW),
    .memToRegE(memToRegE), .memToRegM(memToRegM), .branchD(branchD),
    .fwdAE(fwdAE), .fwdBE(fwdBE), .fwdAD(fwdAD), .fwdBD(fwdBD),
    .stallF(stallF), .stallD(stallD), .flushE(flushE)
  );

  // Reference model written from the requirements
  function automatic logic [1:0] refSelE(logic [RB-1:0] src);
    if (src != 0 && regWrM && src == dstM) return 2'b10;
    if (src != 0 && regWrW && src == dstW) return 2'b01;
    return 2'b00;
  endfunction

  function automatic logic refSelD(logic [RB-1:0] src);
    return src != 0 && regWrM && src == dstM;
  endfunction

  function automatic logic refHold();
    logic lu, br;
    lu = memToRegE && (rsD == rtE || rtD == rtE);
    br = branchD && ((regWrE && (dstE == rsD || dstE == rtD)) ||
                     (memToRegM && (dstM == rsD || dstM == rtD)));
    return lu || br;
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    testCount++;
    if (act != exp) begin
      failCount++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic checkAll(string tag);
    logic h;
    h = refHold();
    check(tag, "fwdAE", fwdAE, refSelE(rsE));
    check(tag, "fwdBE", fwdBE, refSelE(rtE));
    check(tag, "fwdAD", fwdAD, refSelD(rsD));
    check(tag, "fwdBD", fwdBD, refSelD(rtD));
    check(tag, "stallF", stallF, h);
    check(tag, "stallD", stallD, h);
    check(tag, "flushE", flushE, h);
  endtask

  task automatic clearIn();
    {rsD, rtD, rsE, rtE, dstE, dstM, dstW} = '0;
    {regWrE, regWrM, regWrW, memToRegE, memToRegM, branchD} = '0;
  endtask

  // Inputs change at negedge; outputs sampled 1 ns later, same cycle (R11)
  task automatic settle();
    @(negedge clk);
    #1;
  endtask

  initial begin
    clearIn();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    check("R10", "idle stall", stallF, 0);
    check("R10", "idle fwdAE", fwdAE, 0);

    clearIn(); rsE = 3; dstM = 3; regWrM = 1; settle();
    check("R1", "mem bypass", fwdAE, 2);
    clearIn(); rsE = 3; dstW = 3; regWrW = 1; dstM = 4; regWrM = 1; settle();
    check("R2", "wb bypass", fwdAE, 1);
    clearIn(); rsE = 3; dstW = 3; regWrW = 1; settle();
    regWrW = 0; #1;
    check("R11", "same-cycle drop", fwdAE, 0);
    clearIn(); rsE = 6; dstM = 6; dstW = 6; regWrM = 1; regWrW = 1; settle();
    check("R3", "both match A", fwdAE, 2);
    clearIn(); rtE = 7; dstM = 7; dstW = 7; regWrM = 1; regWrW = 1; settle();
    check("R3", "both match B", fwdBE, 2);
    clearIn(); regWrM = 1; regWrW = 1; settle();
    check("R4", "zero A exec", fwdAE, 0);
    check("R4", "zero B exec", fwdBE, 0);
    check("R4", "zero A dec", fwdAD, 0);
    check("R4", "zero B dec", fwdBD, 0);
    clearIn(); rtE = 9; dstW = 9; regWrW = 1; settle();
    check("R5", "B wb bypass", fwdBE, 1);
    clearIn(); rsD = 5; rtD = 8; dstM = 5; regWrM = 1; settle();
    check("R6", "dec A", fwdAD, 1);
    check("R6", "dec B miss", fwdBD, 0);
    clearIn(); rtD = 2; rtE = 2; memToRegE = 1; settle();
    check("R7", "load use", stallF, 1);
    check("R10", "flush with load use", flushE, 1);
    clearIn(); rtD = 4; dstE = 4; regWrE = 1; branchD = 1; settle();
    check("R8", "branch on exec", stallD, 1);
    branchD = 0; #1;
    check("R8", "no branch", stallD, 0);
    clearIn(); rsD = 11; dstM = 11; memToRegM = 1; branchD = 1; settle();
    check("R9", "branch on load mem", flushE, 1);
    clearIn(); rsD = 1; rtE = 1; memToRegE = 1; rtD = 2; dstE = 2; regWrE = 1;
    branchD = 1; settle();
    checkAll("R10");

    // Random sweep over a small register range to force overlaps
    void'($urandom(32'd2024));
    for (int n = 0; n < 500; n++) begin
      rsD = RB'($urandom % 4); rtD = RB'($urandom % 4);
      rsE = RB'($urandom % 4); rtE = RB'($urandom % 4);
      dstE = RB'($urandom % 4); dstM = RB'($urandom % 4); dstW = RB'($urandom % 4);
      {regWrE, regWrM, regWrW} = 3'($urandom);
      {memToRegE, memToRegM, branchD} = 3'($urandom);
      settle();
      checkAll("R1/R2/R3/R5/R6/R7/R8/R9");
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      testCount++;
      failCount++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end
endmodule